// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit carries out the architectural side effects of the two trap-return instructions: return from supervisor mode and return from machine mode. A request gives the current privilege level, the virtualization flag, the machine and hypervisor status words, both saved exception PCs, and the configuration flags: compressed instructions enabled, hypervisor extension present, privileged-spec revision 1.12 or later, and memory protection present together with its rule count. The unit runs the legality checks in a fixed order. It then returns either an exception code, or the rewritten status words together with the new privilege, the new virtualization flag, the return PC and a one-shot request to swap the hypervisor shadow registers.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel, with one register stage in between. A request is accepted on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty, or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every result output holds its value. The consumer commits the returned state, and acts on `rsp_swap`, once per result handshake.

Privilege encoding is U=0, S=1, M=3. The status bit positions are the architectural ones, because neighbouring logic decodes them. In the machine status word: SIE=1, MIE=3, SPIE=5, MPIE=7, SPP=8, MPP=12:11, MPRV=17, TSR=22, MPV=39. In the hypervisor status word: SPV=7, VTSR=22.

Top module: `trapret_unit`

## Requirements
- R1: After reset `rsp_valid` is 0. A request accepted at a clock edge produces `rsp_valid`=1 after that edge. `req_ready` equals `!rsp_valid || rsp_ready`, and a result is removed by a handshake with `rsp_ready`=1.
- R2: While `rsp_valid`=1 and `rsp_ready`=0, every result output stays unchanged.
- R3: A supervisor return at privilege U raises illegal instruction (code 2). This check comes before all other checks.
- R4: For either return, when compressed instructions are disabled and bit 0 or bit 1 of the return PC is set, the unit raises misaligned fetch (code 0). This check comes right after the privilege check.
- R5: A supervisor return at privilege S with TSR=1 raises illegal instruction (code 2). Otherwise, with the hypervisor present, virtualization on and VTSR=1, it raises virtual instruction (code 22).
- R6: A successful supervisor return sets SIE to old SPIE, SPIE to 1 and SPP to 0. The new privilege is S if old SPP was 1 and U otherwise. The return PC is the supervisor exception PC.
- R7: A successful supervisor return clears MPRV when the 1.12 flag is set, and leaves MPRV unchanged otherwise.
- R8: A successful supervisor return with the hypervisor present and virtualization off takes the new virtualization flag from SPV, clears SPV and raises `rsp_swap` if SPV was 1. In every other case the virtualization flag and the hypervisor status word are unchanged.
- R9: A machine return below M raises illegal instruction (code 2). On success it sets MIE to old MPIE, MPIE to 1, MPP to 0 and MPV to 0. The new privilege is old MPP and the return PC is the machine exception PC. With the hypervisor present, the new virtualization flag is old MPV and `rsp_swap` equals old MPV.
- R10: A successful machine return clears MPRV only when the 1.12 flag is set and old MPP is not M.
- R11: A machine return with memory protection present, a rule count of 0 and old MPP not M raises fetch access fault (code 1). This check comes after the misaligned check.
- R12: When an exception is raised, the status words, privilege and virtualization flag come back unchanged and `rsp_swap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Virtualization currently on |
| mstatus_in | input | 64 | Machine status word |
| hstatus_in | input | 64 | Hypervisor status word |
| sepc_in | input | XLEN | Supervisor exception PC |
| mepc_in | input | XLEN | Machine exception PC |
| c_enabled | input | 1 | Compressed instructions enabled |
| h_present | input | 1 | Hypervisor extension present |
| spec_v112 | input | 1 | Privileged spec 1.12 or later |
| pmp_present | input | 1 | Memory protection implemented |
| pmp_rule_count | input | RULE_W | Number of memory-protection rules |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_exc | output | 1 | Exception raised |
| rsp_code | output | 5 | Exception code |
| rsp_mstatus | output | 64 | New machine status word |
| rsp_hstatus | output | 64 | New hypervisor status word |
| rsp_priv | output | 2 | New privilege |
| rsp_virt | output | 1 | New virtualization flag |
| rsp_pc | output | XLEN | Return PC |
| rsp_swap | output | 1 | Swap hypervisor shadow registers |

## Verification
The hardest cases to reach are the ones where several checks fail at once. One example is a supervisor return at U with a misaligned PC, TSR and VTSR all set. Another is a machine return with a misaligned PC and zero protection rules. Only the first check in the order may report. The directed vectors stack these faults deliberately. The random stimulus biases the PC low bits towards zero, the rule count towards zero and the privilege towards legal values, so that stacked faults and the success paths (SPV swap, conditional MPRV clear) both occur often. Random stalls on `rsp_ready` exercise the hold behaviour.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  localparam int SW = 64;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // machine status bit positions (decoded by neighbouring logic)
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_MPRV = 17;
  localparam int B_TSR  = 22;
  localparam int B_MPV  = 39;
  // hypervisor status bit positions
  localparam int B_SPV  = 7;
  localparam int B_VTSR = 22;

  localparam logic [4:0] EXC_MISALIGN  = 5'd0;
  localparam logic [4:0] EXC_FETCH_ACC = 5'd1;
  localparam logic [4:0] EXC_ILLEGAL   = 5'd2;
  localparam logic [4:0] EXC_VIRT      = 5'd22;

  typedef struct packed {
    logic          exc;
    logic [4:0]    code;
    logic [SW-1:0] mstatus;
    logic [SW-1:0] hstatus;
    logic [1:0]    priv;
    logic          virt;
    logic          swap;
  } tr_result_t;
endpackage

// File: rtl/trapret_sret.sv
module trapret_sret
  import trapret_pkg::*;
(
  input  logic [1:0]    priv,
  input  logic          virt,
  input  logic [SW-1:0] mstatus,
  input  logic [SW-1:0] hstatus,
  input  logic [1:0]    epc_lo,
  input  logic          c_en,
  input  logic          h_en,
  input  logic          v112,
  output tr_result_t    res
);
  logic bad_priv, misal, tsr_trap, vtsr_trap;
  logic [SW-1:0] ms_new, hs_new;
  logic virt_new, swap_new;

  assign bad_priv  = (priv == PRIV_U);
  assign misal     = !c_en && (epc_lo != 2'b00);
  assign tsr_trap  = mstatus[B_TSR] && (priv != PRIV_M);
  assign vtsr_trap = h_en && virt && hstatus[B_VTSR];

  always_comb begin
    ms_new          = mstatus;
    ms_new[B_SIE]   = mstatus[B_SPIE];
    ms_new[B_SPIE]  = 1'b1;
    ms_new[B_SPP]   = 1'b0;
    if (v112) ms_new[B_MPRV] = 1'b0;

    hs_new   = hstatus;
    virt_new = virt;
    swap_new = 1'b0;
    if (h_en && !virt) begin
      hs_new[B_SPV] = 1'b0;
      virt_new      = hstatus[B_SPV];
      swap_new      = hstatus[B_SPV];
    end
  end

  always_comb begin
    res.exc  = 1'b1;
    res.code = EXC_ILLEGAL;
    if (bad_priv)       res.code = EXC_ILLEGAL;
    else if (misal)     res.code = EXC_MISALIGN;
    else if (tsr_trap)  res.code = EXC_ILLEGAL;
    else if (vtsr_trap) res.code = EXC_VIRT;
    else                res.exc  = 1'b0;

    if (res.exc) begin
      res.mstatus = mstatus;
      res.hstatus = hstatus;
      res.priv    = priv;
      res.virt    = virt;
      res.swap    = 1'b0;
    end else begin
      res.mstatus = ms_new;
      res.hstatus = hs_new;
      res.priv    = mstatus[B_SPP] ? PRIV_S : PRIV_U;
      res.virt    = virt_new;
      res.swap    = swap_new;
    end
  end
endmodule

// File: rtl/trapret_mret.sv
module trapret_mret
  import trapret_pkg::*;
#(
  parameter int RULE_W = 7
) (
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [SW-1:0]     mstatus,
  input  logic [SW-1:0]     hstatus,
  input  logic [1:0]        epc_lo,
  input  logic              c_en,
  input  logic              h_en,
  input  logic              v112,
  input  logic              pmp_en,
  input  logic [RULE_W-1:0] rules,
  output tr_result_t        res
);
  logic [1:0] prev_priv;
  logic prev_virt, bad_priv, misal, no_rules;
  logic [SW-1:0] ms_new;

  assign prev_priv = mstatus[B_MPP+1:B_MPP];
  assign prev_virt = mstatus[B_MPV];
  assign bad_priv  = (priv != PRIV_M);
  assign misal     = !c_en && (epc_lo != 2'b00);
  assign no_rules  = pmp_en && (rules == '0) && (prev_priv != PRIV_M);

  always_comb begin
    ms_new                   = mstatus;
    ms_new[B_MIE]            = mstatus[B_MPIE];
    ms_new[B_MPIE]           = 1'b1;
    ms_new[B_MPP+1:B_MPP]    = PRIV_U;
    ms_new[B_MPV]            = 1'b0;
    if (v112 && (prev_priv != PRIV_M)) ms_new[B_MPRV] = 1'b0;
  end

  always_comb begin
    res.exc  = 1'b1;
    res.code = EXC_ILLEGAL;
    if (bad_priv)      res.code = EXC_ILLEGAL;
    else if (misal)    res.code = EXC_MISALIGN;
    else if (no_rules) res.code = EXC_FETCH_ACC;
    else               res.exc  = 1'b0;

    res.hstatus = hstatus;
    if (res.exc) begin
      res.mstatus = mstatus;
      res.priv    = priv;
      res.virt    = virt;
      res.swap    = 1'b0;
    end else begin
      res.mstatus = ms_new;
      res.priv    = prev_priv;
      res.virt    = h_en ? prev_virt : virt;
      res.swap    = h_en && prev_virt;
    end
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RULE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic [63:0]       mstatus_in,
  input  logic [63:0]       hstatus_in,
  input  logic [XLEN-1:0]   sepc_in,
  input  logic [XLEN-1:0]   mepc_in,
  input  logic              c_enabled,
  input  logic              h_present,
  input  logic              spec_v112,
  input  logic              pmp_present,
  input  logic [RULE_W-1:0] pmp_rule_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_exc,
  output logic [4:0]        rsp_code,
  output logic [63:0]       rsp_mstatus,
  output logic [63:0]       rsp_hstatus,
  output logic [1:0]        rsp_priv,
  output logic              rsp_virt,
  output logic [XLEN-1:0]   rsp_pc,
  output logic              rsp_swap
);
  tr_result_t s_res, m_res, sel_res, res_q;
  logic [XLEN-1:0] pc_q;
  logic valid_q, mret_q, accept;

  trapret_sret u_sret (
    .priv(cur_priv), .virt(cur_virt), .mstatus(mstatus_in), .hstatus(hstatus_in),
    .epc_lo(sepc_in[1:0]), .c_en(c_enabled), .h_en(h_present), .v112(spec_v112),
    .res(s_res)
  );

  trapret_mret #(.RULE_W(RULE_W)) u_mret (
    .priv(cur_priv), .virt(cur_virt), .mstatus(mstatus_in), .hstatus(hstatus_in),
    .epc_lo(mepc_in[1:0]), .c_en(c_enabled), .h_en(h_present), .v112(spec_v112),
    .pmp_en(pmp_present), .rules(pmp_rule_count), .res(m_res)
  );

  assign sel_res   = req_is_mret ? m_res : s_res;
  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mret_q  <= 1'b0;
      res_q   <= '0;
      pc_q    <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      mret_q  <= req_is_mret;
      res_q   <= sel_res;
      pc_q    <= req_is_mret ? mepc_in : sepc_in;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_exc     = res_q.exc;
  assign rsp_code    = res_q.code;
  assign rsp_mstatus = res_q.mstatus;
  assign rsp_hstatus = res_q.hstatus;
  assign rsp_priv    = res_q.priv;
  assign rsp_virt    = res_q.virt;
  assign rsp_pc      = pc_q;
  assign rsp_swap    = res_q.swap;

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mstatus) && $stable(rsp_code)
      && $stable(rsp_exc) && $stable(rsp_priv) && $stable(rsp_pc) && $stable(rsp_swap)));

  // R12
  exc_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc) |-> !rsp_swap);

  // R12
  exc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc) |-> (rsp_code == EXC_MISALIGN || rsp_code == EXC_FETCH_ACC
      || rsp_code == EXC_ILLEGAL || rsp_code == EXC_VIRT));

  // R6
  sret_spp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exc && !mret_q) |-> (!rsp_mstatus[B_SPP] && rsp_mstatus[B_SPIE]));

  // R9
  mret_mpp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exc && mret_q) |-> (rsp_mstatus[B_MPP+1:B_MPP] == PRIV_U
      && !rsp_mstatus[B_MPV] && rsp_mstatus[B_MPIE]));
endmodule

// File: tb/trapret_unit_test.sv
module trapret_unit_test;
  localparam int XLEN = 64;
  localparam int RW   = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_is_mret = 0;
  logic [1:0] cur_priv = 0;
  logic cur_virt = 0;
  logic [63:0] mstatus_in = 0, hstatus_in = 0;
  logic [XLEN-1:0] sepc_in = 0, mepc_in = 0;
  logic c_enabled = 0, h_present = 0, spec_v112 = 0, pmp_present = 0;
  logic [RW-1:0] pmp_rule_count = 0;
  logic rsp_valid, rsp_ready = 0, rsp_exc, rsp_virt, rsp_swap;
  logic [4:0] rsp_code;
  logic [63:0] rsp_mstatus, rsp_hstatus;
  logic [1:0] rsp_priv;
  logic [XLEN-1:0] rsp_pc;

  int vectors = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trapret_unit #(.XLEN(XLEN), .RULE_W(RW)) uut (.*);

  // expected values
  logic e_exc, e_virt, e_swap;
  logic [4:0] e_code;
  logic [63:0] e_ms, e_hs;
  logic [1:0] e_priv;
  logic [XLEN-1:0] e_pc;

  task automatic model();
    logic [63:0] ms, hs;
    logic [1:0] pp;
    ms = mstatus_in; hs = hstatus_in;
    e_exc = 0; e_code = 0; e_swap = 0; e_virt = cur_virt; e_priv = cur_priv;
    if (!req_is_mret) begin
      e_pc = sepc_in;
      if (cur_priv == 2'd0) begin e_exc = 1; e_code = 2; end
      else if (!c_enabled && sepc_in[1:0] != 0) begin e_exc = 1; e_code = 0; end
      else if (ms[22] && cur_priv != 2'd3) begin e_exc = 1; e_code = 2; end
      else if (h_present && cur_virt && hs[22]) begin e_exc = 1; e_code = 22; end
      if (!e_exc) begin
        e_priv = ms[8] ? 2'd1 : 2'd0;
        ms[1] = mstatus_in[5]; ms[5] = 1; ms[8] = 0;
        if (spec_v112) ms[17] = 0;
        if (h_present && !cur_virt) begin
          e_virt = hstatus_in[7]; e_swap = hstatus_in[7]; hs[7] = 0;
        end
      end
    end else begin
      e_pc = mepc_in;
      pp = mstatus_in[12:11];
      if (cur_priv != 2'd3) begin e_exc = 1; e_code = 2; end
      else if (!c_enabled && mepc_in[1:0] != 0) begin e_exc = 1; e_code = 0; end
      else if (pmp_present && pmp_rule_count == 0 && pp != 2'd3) begin e_exc = 1; e_code = 1; end
      if (!e_exc) begin
        e_priv = pp;
        ms[3] = mstatus_in[7]; ms[7] = 1; ms[12:11] = 0; ms[39] = 0;
        if (spec_v112 && pp != 2'd3) ms[17] = 0;
        if (h_present) begin e_virt = mstatus_in[39]; e_swap = mstatus_in[39]; end
      end
    end
    e_ms = ms; e_hs = hs;
  endtask

  task automatic fail(string req, string what, logic [63:0] act, logic [63:0] exp);
    bad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic compare(string tag);
    string rc, rs, rv;
    rc = req_is_mret ? "R9 R4 R11" : "R3 R4 R5";
    rs = req_is_mret ? "R9 R10 R12" : "R6 R7 R12";
    rv = req_is_mret ? "R9 R12" : "R8 R12";
    vectors++;
    if (rsp_valid !== 1'b1) fail("R1", {tag, " valid"}, 64'(rsp_valid), 1);
    if (rsp_exc !== e_exc) fail(rc, {tag, " exc"}, 64'(rsp_exc), 64'(e_exc));
    if (e_exc && rsp_code !== e_code) fail(rc, {tag, " code"}, 64'(rsp_code), 64'(e_code));
    if (rsp_mstatus !== e_ms) fail(rs, {tag, " mstatus"}, rsp_mstatus, e_ms);
    if (rsp_hstatus !== e_hs) fail(rv, {tag, " hstatus"}, rsp_hstatus, e_hs);
    if (rsp_priv !== e_priv) fail(rs, {tag, " priv"}, 64'(rsp_priv), 64'(e_priv));
    if (rsp_virt !== e_virt) fail(rv, {tag, " virt"}, 64'(rsp_virt), 64'(e_virt));
    if (rsp_swap !== e_swap) fail(rv, {tag, " swap"}, 64'(rsp_swap), 64'(e_swap));
    if (!e_exc && rsp_pc !== e_pc) fail(rs, {tag, " pc"}, rsp_pc, e_pc);
  endtask

  task automatic apply(string tag, bit stall);
    @(negedge clk);
    if (req_ready !== 1'b1) fail("R1", {tag, " ready"}, 64'(req_ready), 1);
    model();
    req_valid = 1; rsp_ready = 0;
    @(posedge clk); #1;
    req_valid = 0;
    compare(tag);
    if (stall) begin
      @(posedge clk); #1;
      vectors++;
      // R2: held under back-pressure; ready low while full
      if (req_ready !== 1'b0) fail("R1", {tag, " ready full"}, 64'(req_ready), 0);
      compare({tag, " R2 stall"});
    end
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
    vectors++;
    if (rsp_valid !== 1'b0) fail("R1", {tag, " drain"}, 64'(rsp_valid), 0);
  endtask

  task automatic setup(bit m, logic [1:0] p, logic v, logic [63:0] ms, logic [63:0] hs,
                       logic [63:0] pc, logic c, logic h, logic ver, logic pmp, int rules);
    req_is_mret = m; cur_priv = p; cur_virt = v; mstatus_in = ms; hstatus_in = hs;
    sepc_in = pc; mepc_in = pc ^ 64'h1000; c_enabled = c; h_present = h;
    spec_v112 = ver; pmp_present = pmp; pmp_rule_count = RW'(rules);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    vectors++;
    if (rsp_valid !== 1'b0) fail("R1", "reset valid", 64'(rsp_valid), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    vectors++;
    if (rsp_valid !== 1'b0) fail("R1", "post-reset valid", 64'(rsp_valid), 0);

    // R3: U-mode sret with every later fault stacked
    setup(0, 2'd0, 1, 64'h400000, 64'h400000, 64'h2, 0, 1, 1, 0, 1);
    apply("R3 stacked", 0);
    // R4: misaligned beats TSR
    setup(0, 2'd1, 0, 64'h400000, 0, 64'h1, 0, 0, 1, 0, 1);
    apply("R4 sret misalign", 0);
    // R4: misaligned tolerated with compressed on
    setup(0, 2'd1, 0, 64'h120, 0, 64'h2, 1, 0, 0, 0, 1);
    apply("R4 c on", 1);
    // R5: TSR at S, and TSR ignored at M
    setup(0, 2'd1, 0, 64'h400000, 0, 64'h100, 1, 0, 0, 0, 1);
    apply("R5 tsr", 0);
    setup(0, 2'd3, 0, 64'h400120, 0, 64'h100, 1, 0, 1, 0, 1);
    apply("R5 tsr at M", 0);
    setup(0, 2'd1, 1, 64'h0, 64'h400080, 64'h100, 1, 1, 0, 0, 1);
    apply("R5 vtsr", 0);
    // R8: SPV swap, and no swap when virtualization on
    setup(0, 2'd1, 0, 64'h20120, 64'h80, 64'h200, 1, 1, 1, 0, 1);
    apply("R8 spv", 1);
    setup(0, 2'd1, 1, 64'h20120, 64'h80, 64'h200, 1, 1, 0, 0, 1);
    apply("R8 virt on R7 keep mprv", 0);
    // R9: mret below M
    setup(1, 2'd1, 0, 64'h1880, 0, 64'h0, 1, 0, 0, 0, 1);
    apply("R9 priv", 0);
    // R11: zero rules, and misaligned outranks it
    setup(1, 2'd3, 0, 64'h0800, 0, 64'h0, 1, 0, 0, 1, 0);
    apply("R11 no rules", 0);
    setup(1, 2'd3, 0, 64'h0800, 0, 64'h1002, 0, 0, 0, 1, 0);
    apply("R11 R4 order", 0);
    // R10: MPRV kept when MPP==M, cleared otherwise; MPV swap
    setup(1, 2'd3, 0, 64'h8000021880, 0, 64'h0, 1, 1, 1, 1, 0);
    apply("R10 mpp M", 1);
    setup(1, 2'd3, 0, 64'h8000020880, 0, 64'h0, 1, 1, 1, 1, 3);
    apply("R10 mpp S mpv", 0);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] ms, hs, pc;
      logic [1:0] p;
      int r;
      ms = {$urandom, $urandom};
      hs = {$urandom, $urandom};
      pc = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) pc[1:0] = 0;
      p = 2'($urandom_range(0, 3));
      if (p == 2'd2) p = 2'd3;
      r = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 100);
      setup(1'($urandom), p, 1'($urandom), ms, hs, pc, 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), r);
      apply("random", 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule